// File: doc/BRIEF.md
# Timer DMA Burst Access Redirector

This block lets one timer event drive a whole chain of DMA transfers through a single virtual data register. When a trigger arrives with no burst running, the block captures a base offset and a transfer count from its control register. It then raises a DMA request. Each acknowledged transfer reads or writes the real timer register at base plus the running index. The block raises the next request after a one-cycle gap, and this repeats until the programmed count has been served.

A processor port reaches the real register array and the control register directly. Typical uses are reloading a run of compare registers on every update event with half-word writes, and sampling several registers in a row into memory. Registers past the last implemented one read as zero and discard writes. The block holds only a plain register array in place of the timer core.

Top module: `tmr_burst_redirect`

## Requirements
- R1: After synchronous active-low reset, `dma_req` is 0, every timer register reads 0, and the control register reads 0.
- R2: A one-cycle `evt` while idle makes `dma_req` rise at the next clock edge. The burst captures the control register's base and length as they stood before that edge, and its index starts at 0.
- R3: Acknowledged transfer k (k from 0) targets register base+k. With `dma_we`=1 it writes `dma_wdata` there. `dma_rdata` always shows the register at base+k.
- R4: A length field of n gives exactly n+1 acknowledged transfers. `dma_req` drops after the last acknowledge and stays low until the next trigger. This holds up to n=31.
- R5: `dma_req` stays high until acknowledged. After a non-final acknowledge it is low for exactly one cycle and then high again.
- R6: An `evt` during a burst is ignored. It neither restarts nor shifts the index.
- R7: A target index at or above NREG (20 by default) reads 0 on `dma_rdata` and ignores DMA writes. A processor address in NREG..30 also reads 0.
- R8: A control-register write during a burst does not change the running burst. It applies only from the next trigger.
- R9: The processor port writes register `cpu_addr` when `cpu_we`=1 and `cpu_addr`<NREG. Address 31 is the control register, with length in bits [4:0] and base in bits [9:5]. `cpu_rdata` shows the addressed word combinationally. A DMA write takes priority over a processor write to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt | input | 1 | Timer trigger event that starts a burst |
| dma_req | output | 1 | DMA request, one outstanding at a time |
| dma_ack | input | 1 | DMA acknowledge; the transfer happens on this edge |
| dma_we | input | 1 | 1 = DMA writes the virtual register, 0 = reads |
| dma_wdata | input | 16 | DMA write data |
| dma_rdata | output | 16 | Redirected read data for the virtual register |
| cpu_addr | input | 5 | Processor register address (31 = control) |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data |

## Verification
The assertions check the request handshake on every cycle. They cover holding the request until acknowledge, the one-cycle gap after a non-final acknowledge, and the drop after the final one. They also cover the index starting at zero, stepping by one per acknowledge and otherwise staying frozen together with the captured base even when triggers arrive, and reads beyond the array returning zero. Some properties only the bench's scenarios can show. These are the exact number of transfers per burst, the values that land in the right registers, and the deferred effect of a control write made mid-burst. The bench shows them through a cycle-by-cycle model and through register readback.

// File: rtl/tbr_pkg.sv
// Package: shared types and widths for the timer DMA burst redirector.
// Assumes: 5-bit base and length fields in the control register.
package tbr_pkg;
    localparam int FLD_W = 5;
    localparam int IDX_W = FLD_W + 1;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_GAP  = 2'd2
    } sq_state_t;

    typedef struct packed {
        logic [FLD_W-1:0] base;
        logic [FLD_W-1:0] len;
    } burst_cfg_t;
endpackage

// File: rtl/tbr_ctlreg.sv
// Module: burst control register holding the base offset and length field.
// Assumes: packed layout {base, len}, len in the low bits; written only by the processor port.
module tbr_ctlreg
    import tbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  burst_cfg_t wr_cfg,
    output burst_cfg_t cfg
);
    // Hold the configuration; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= wr_cfg;
        end
    end
endmodule

// File: rtl/tbr_sequencer.sv
// Module: burst request sequencer and transfer index counter.
// Assumes: one request outstanding; ack is only honoured while req is high;
// config is captured at burst start so later control writes wait for the next burst.
module tbr_sequencer
    import tbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             ack,
    input  burst_cfg_t       cfg,
    output logic             req,
    output logic             busy,
    output logic             last,
    output logic             xfer,
    output logic [FLD_W-1:0] idx,
    output logic [FLD_W-1:0] base_l
);
    sq_state_t        state;
    logic [FLD_W-1:0] len_l;

    // Decode handshake signals from the state and the captured length.
    always_comb begin
        req  = (state == SQ_REQ);
        busy = (state != SQ_IDLE);
        last = (idx == len_l);
        xfer = req && ack;
    end

    // Advance the burst: capture on trigger, step on ack, pause one cycle between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            idx    <= '0;
            base_l <= '0;
            len_l  <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (evt) begin
                        base_l <= cfg.base;
                        len_l  <= cfg.len;
                        idx    <= '0;
                        state  <= SQ_REQ;
                    end
                end
                SQ_REQ: begin
                    if (ack) begin
                        if (last) begin
                            state <= SQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    state <= SQ_REQ;
                end
                default: begin
                    state <= SQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/tbr_regfile.sv
// Module: stand-in timer register array with a processor port and a redirected DMA port.
// Assumes: DMA write wins over a processor write to the same entry in the same cycle;
// indices at or above NREG read zero and are not stored.
module tbr_regfile #(
    parameter int NREG  = 20,
    parameter int DW    = 16,
    parameter int AW    = 5,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_idx,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rd,
    input  logic             dma_we,
    input  logic [IDX_W-1:0] dma_idx,
    input  logic [DW-1:0]    dma_wdata,
    output logic [DW-1:0]    dma_rd
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One entry: DMA write first, else processor write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (dma_we && (dma_idx == IDX_W'(g))) begin
                regs[g] <= dma_wdata;
            end else if (cpu_we && (cpu_idx == AW'(g))) begin
                regs[g] <= cpu_wdata;
            end
        end
    end

    // Select read words for both ports; unmatched indices give zero.
    always_comb begin
        cpu_rd = '0;
        dma_rd = '0;
        for (int i = 0; i < NREG; i++) begin
            if (cpu_idx == AW'(i)) cpu_rd = regs[i];
            if (dma_idx == IDX_W'(i)) dma_rd = regs[i];
        end
    end
endmodule

// File: rtl/tmr_burst_redirect.sv
// Module: top of the timer DMA burst redirector.
// Assumes: CTL_ADDR lies at or above NREG; DW is at least 10 so the control word fits.
module tmr_burst_redirect
    import tbr_pkg::*;
#(
    parameter int          NREG     = 20,
    parameter int          DW       = 16,
    parameter int          AW       = 5,
    parameter logic [4:0]  CTL_ADDR = 5'd31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    output logic          dma_req,
    input  logic          dma_ack,
    input  logic          dma_we,
    input  logic [DW-1:0] dma_wdata,
    output logic [DW-1:0] dma_rdata,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata
);
    localparam int CFG_W = 2 * FLD_W;

    burst_cfg_t       cfg;
    logic             ctl_sel;
    logic             seq_busy;
    logic             seq_last;
    logic             seq_xfer;
    logic [FLD_W-1:0] seq_idx;
    logic [FLD_W-1:0] seq_base;
    logic [IDX_W-1:0] seq_tgt;
    logic [DW-1:0]    rf_cpu_rd;

    // Decode the processor address and form the redirected index.
    always_comb begin
        ctl_sel = (cpu_addr == CTL_ADDR);
        seq_tgt = {1'b0, seq_base} + {1'b0, seq_idx};
    end

    tbr_ctlreg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cpu_we && ctl_sel),
        .wr_cfg (burst_cfg_t'(cpu_wdata[CFG_W-1:0])),
        .cfg    (cfg)
    );

    tbr_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .ack    (dma_ack),
        .cfg    (cfg),
        .req    (dma_req),
        .busy   (seq_busy),
        .last   (seq_last),
        .xfer   (seq_xfer),
        .idx    (seq_idx),
        .base_l (seq_base)
    );

    tbr_regfile #(
        .NREG  (NREG),
        .DW    (DW),
        .AW    (AW),
        .IDX_W (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we && !ctl_sel),
        .cpu_idx   (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rd    (rf_cpu_rd),
        .dma_we    (seq_xfer && dma_we),
        .dma_idx   (seq_tgt),
        .dma_wdata (dma_wdata),
        .dma_rd    (dma_rdata)
    );

    // Processor read mux: control word or register array.
    always_comb begin
        if (ctl_sel) cpu_rdata = DW'(cfg);
        else         cpu_rdata = rf_cpu_rd;
    end
endmodule

// File: rtl/tbr_checker.sv
// Module: protocol checker for the burst redirector, bound into the top.
module tbr_checker #(
    parameter int NREG = 20,
    parameter int DW   = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_req,
    input logic          dma_ack,
    input logic [DW-1:0] dma_rdata,
    input logic          busy,
    input logic          last,
    input logic [4:0]    idx,
    input logic [4:0]    base_l,
    input logic [5:0]    tgt
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_ack |=> dma_req); // R5
    AST_ONE_CYCLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack && !last |=> !dma_req ##1 dma_req); // R5
    AST_FINAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack && last |=> !dma_req && !busy); // R4
    AST_IDX_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> idx == 5'd0); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack && !last |=> idx == $past(idx) + 5'd1); // R3
    AST_TRIGGER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(dma_req && dma_ack) |=> $stable(idx) && $stable(base_l)); // R6
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tgt) >= NREG) |-> dma_rdata == '0); // R7
endmodule

bind tmr_burst_redirect tbr_checker #(.NREG(NREG), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .dma_rdata (dma_rdata),
    .busy      (seq_busy),
    .last      (seq_last),
    .idx       (seq_idx),
    .base_l    (seq_base),
    .tgt       (seq_tgt)
);

// File: tb/sim_tmr_burst_redirect.sv
// Bench: behavioural per-cycle model compared on every clock, plus directed readback.
module sim_tmr_burst_redirect;
    localparam int NREG = 20;
    localparam int CTL  = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic        dma_we = 1'b0;
    logic [15:0] dma_wdata = '0;
    logic [15:0] dma_rdata;
    logic [4:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_en = 0;
    string phase = "R1";

    int m_reg [NREG];
    int m_cb = 0, m_cl = 0, m_bb = 0, m_bl = 0, m_k = 0, m_st = 0;

    always #5 clk = ~clk;

    tmr_burst_redirect u0 (
        .clk(clk), .rst_n(rst_n), .evt(evt), .dma_req(dma_req), .dma_ack(dma_ack),
        .dma_we(dma_we), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference model: state after each clock edge.
    always @(posedge clk) begin
        int ob, ol, t;
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_cb = 0; m_cl = 0; m_bb = 0; m_bl = 0; m_k = 0; m_st = 0;
        end else begin
            ob = m_cb; ol = m_cl;
            t  = m_bb + m_k;
            if (cpu_we) begin
                if (int'(cpu_addr) < NREG) m_reg[cpu_addr] = int'(cpu_wdata);
                else if (int'(cpu_addr) == CTL) begin
                    m_cb = (int'(cpu_wdata) >> 5) & 31;
                    m_cl = int'(cpu_wdata) & 31;
                end
            end
            case (m_st)
                0: if (evt) begin m_bb = ob; m_bl = ol; m_k = 0; m_st = 1; end
                1: if (dma_ack) begin
                    if (dma_we && t < NREG) m_reg[t] = int'(dma_wdata);
                    if (m_k == m_bl) m_st = 0;
                    else begin m_k++; m_st = 2; end
                end
                default: m_st = 1;
            endcase
        end
    end

    function automatic int exp_dma_rd();
        int t = m_bb + m_k;
        return (t < NREG) ? m_reg[t] : 0;
    endfunction

    function automatic int exp_cpu_rd();
        if (int'(cpu_addr) < NREG) return m_reg[cpu_addr];
        if (int'(cpu_addr) == CTL) return m_cb * 32 + m_cl;
        return 0;
    endfunction

    // Per-cycle comparison, sampled between edges after inputs settle.
    always @(negedge clk) begin
        #2;
        if (chk_en) begin
            check(dma_req == (m_st == 1), {phase, " dma_req"}, int'(dma_req), int'(m_st == 1));
            check(int'(dma_rdata) == exp_dma_rd(), {phase, " dma_rdata"}, int'(dma_rdata), exp_dma_rd());
            check(int'(cpu_rdata) == exp_cpu_rd(), {phase, " cpu_rdata"}, int'(cpu_rdata), exp_cpu_rd());
        end
    end

    task automatic cpu_wr(input int a, input int d);
        @(negedge clk);
        cpu_addr = 5'(a); cpu_wdata = 16'(d); cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input int a, input int exp, input string tag);
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 5'(a);
        #3;
        check(int'(cpu_rdata) == exp, tag, int'(cpu_rdata), exp);
    endtask

    // Trigger one burst and serve it as the DMA side with varying ack delays.
    task automatic burst(input bit we, input int exp_n, input int wbase,
                         input bit mid_evt, input int mid_ctl, input string tag);
        int acks = 0;
        int idle = 0;
        int dly  = 1;
        bit mid_done = 0;
        @(negedge clk);
        evt = 1'b1; dma_we = we;
        @(negedge clk);
        evt = 1'b0;
        while (idle < 4) begin
            dma_ack = 1'b0; evt = 1'b0; cpu_we = 1'b0;
            if (dma_req) begin
                idle = 0;
                if (dly > 0) dly--;
                else begin
                    dma_ack = 1'b1; dma_wdata = 16'(wbase + acks);
                    acks++; dly = (acks * 7) % 3;
                end
                if (acks == 2 && !mid_done) begin
                    mid_done = 1;
                    if (mid_evt) evt = 1'b1;
                    if (mid_ctl >= 0) begin
                        cpu_addr = 5'(CTL); cpu_wdata = 16'(mid_ctl); cpu_we = 1'b1;
                    end
                end
            end else idle++;
            @(negedge clk);
        end
        dma_ack = 1'b0; evt = 1'b0; cpu_we = 1'b0;
        check(acks == exp_n, {tag, " transfer count"}, acks, exp_n);
    endtask

    initial begin
        #(200000 * 10);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        cpu_addr = 5'(CTL);
        #3;
        check(dma_req == 1'b0, "R1 req in reset", int'(dma_req), 0);
        check(cpu_rdata == 16'd0, "R1 ctl in reset", int'(cpu_rdata), 0);
        rst_n = 1'b1;
        cpu_rd(7, 0, "R1 reg after reset");
        chk_en = 1;

        // R9: processor access to array and control word
        phase = "R9";
        for (int i = 0; i < NREG; i++) cpu_wr(i, 16'h100 + i * 3);
        cpu_rd(13, 16'h100 + 39, "R9 reg readback");
        cpu_wr(CTL, 2 * 32 + 2);
        cpu_rd(CTL, 66, "R9 ctl readback");
        cpu_rd(25, 0, "R7 unmapped cpu address");

        // R2 R3 R4 R5: write burst into registers 2..4
        phase = "R3";
        burst(1'b1, 3, 16'hA000, 0, -1, "R4 len 2");
        cpu_rd(2, 16'hA000, "R3 first target");
        cpu_rd(4, 16'hA002, "R3 last target");
        cpu_rd(5, 16'h100 + 15, "R4 no extra transfer");
        cpu_rd(1, 16'h100 + 3, "R2 below base untouched");

        // R3: read burst from register 0
        phase = "R3 read";
        cpu_wr(CTL, 0 * 32 + 3);
        burst(1'b0, 4, 0, 0, -1, "R4 read len 3");

        // R6: trigger during burst ignored
        phase = "R6";
        cpu_wr(CTL, 5 * 32 + 3);
        burst(1'b1, 4, 16'hB000, 1, -1, "R6 mid trigger");
        cpu_rd(5, 16'hB000, "R6 index not restarted");
        cpu_rd(8, 16'hB003, "R6 last target");

        // R8: control write during burst deferred
        phase = "R8";
        cpu_wr(CTL, 8 * 32 + 1);
        burst(1'b1, 2, 16'hC000, 0, 0, "R8 running burst unchanged");
        cpu_rd(9, 16'hC001, "R8 old config completed");
        burst(1'b1, 1, 16'hD000, 0, -1, "R8 new config applied");
        cpu_rd(0, 16'hD000, "R8 new base used");

        // R7: targets past the array
        phase = "R7";
        cpu_wr(CTL, 17 * 32 + 4);
        burst(1'b1, 5, 16'hE000, 0, -1, "R7 crossing end");
        cpu_rd(19, 16'hE002, "R7 last real register");
        burst(1'b0, 5, 0, 0, -1, "R7 read crossing end");
        cpu_rd(20, 0, "R7 write beyond end dropped");

        // R4: largest length field
        phase = "R4";
        cpu_wr(CTL, 31 * 32 + 31);
        burst(1'b0, 32, 0, 0, -1, "R4 len 31");

        // R9: DMA write wins over same-cycle processor write
        phase = "R9 prio";
        cpu_wr(CTL, 3 * 32 + 0);
        @(negedge clk);
        evt = 1'b1; dma_we = 1'b1;
        @(negedge clk);
        evt = 1'b0;
        dma_ack = 1'b1; dma_wdata = 16'h5A5A;
        cpu_addr = 5'd3; cpu_wdata = 16'h1111; cpu_we = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0; cpu_we = 1'b0;
        cpu_rd(3, 16'h5A5A, "R9 DMA priority");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule